// File: doc/BRIEF.md
# GPIO Input Event Detector

This block conditions the input side of a bank of general-purpose pads and turns pad activity into interrupt events. Every pad input first crosses into the core clock through a two-flop synchronizer. It can then be inverted, and it can be passed through a debounce filter. The filter counts a slow tick supplied from outside and accepts a new value only after that value has held for a power-of-two number of ticks. The conditioned value feeds an event detector. A per-pad trigger field sets the detector to level, single edge, both edges or off.

A detected event sets a sticky per-pad status bit. Software clears the bit by writing 1 to it. Four destination outputs collect the status bits: each destination is the OR, over all pads, of the status bits whose route bit for that destination is set. One pad may route to several destinations at once.

Software reaches the block through a flat register port. Words 0 to NPADS-1 hold the per-pad configuration. Word NPADS holds event status and is write-1-to-clear. Word NPADS+1 holds the conditioned input levels and is read-only. Reads are combinational from the address.

Top module: `gpio_event_detect`

## Requirements
- R1: The pad input passes through two synchronizer flops and then one filter flop. A change driven just before a clock edge appears in the level word on the third clock edge and not before.
- R2: The configuration word is laid out as follows: bits [1:0] trigger, bit 2 invert, bit 3 receive-off, bit 4 debounce enable, bits [8:5] debounce code, bits [12:9] route. With trigger 0 (level), status is set on every cycle in which the conditioned level is 1.
- R3: With trigger 1 (single edge), status is set on a rising edge of the conditioned value. With invert clear this is a rising edge of the pad. With invert set it is a falling edge of the pad, and a rising pad edge sets nothing.
- R4: With trigger 3 (both edges), status is set on each rising and each falling edge.
- R5: With trigger 2 (off), status is never set.
- R6: The invert bit flips the sensed value for both the event detector and the level word. The level word (address NPADS+1, bit p for pad p) reports the conditioned value for every trigger setting.
- R7: Status (address NPADS, bit p for pad p) is sticky. Writing 1 to a bit clears it. A level event that is still present sets the bit again, and a set in the same cycle as a clear takes priority.
- R8: A pad with receive-off set never sets its status bit.
- R9: With debounce enabled and code N (3 to 15), the conditioned value changes only after the sensed value has differed from it for 2^N slow ticks. Codes below 3 behave as 3. Without a tick the filtered value does not change.
- R10: Any return of the input to the filtered value before the count completes restarts the count.
- R11: The destination output dstIrq[d] is 1 exactly when some pad has status 1 and route bit d set. Route bit 0 selects the non-maskable destination, bit 1 the system-management destination, bit 2 the system-control destination and bit 3 the interrupt-controller destination. More than one route bit may be set.
- R12: After reset, status and levels are 0, every configuration word reads 0x0002 (trigger off) and all destination outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| padIn | input | NPADS | Raw pad inputs, asynchronous |
| rtcTick | input | 1 | Slow-tick pulse, one core cycle wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for addr |
| dstIrq | output | 4 | Routed event outputs, one per destination |

## Verification
The bench builds the block with its defaults: four pads and a 16-bit debounce counter. With four pads it can route two pads to overlapping destinations and keep one pad disabled or switched off at the same time. The tick is driven every fourth core cycle. This keeps the counts for codes 0, 3 and 4 short enough to time the full hold, an early read and a bounce restart. A seeded random phase covers every trigger and invert combination against a computed event model.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_DEST = 4;
  localparam int MAX_CODE = 15;
  localparam int MIN_CODE = 3;
  localparam int CNT_W    = MAX_CODE + 1;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_OFF   = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [NUM_DEST-1:0] route;
    logic [3:0]          debCode;
    logic                debEn;
    logic                rxOff;
    logic                invert;
    trig_e               trig;
  } padCfg_t;

  localparam int CFG_W = $bits(padCfg_t);

  typedef struct packed {
    logic              clrStb;
    logic [DATA_W-1:0] clrMask;
  } strobes_t;
endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPADS = 4,
  parameter int AW    = $clog2(NPADS + 2)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [AW-1:0]                addr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NPADS-1:0]             statusVec,
  input  logic [NPADS-1:0]             levelVec,
  output padCfg_t [NPADS-1:0]          cfgVec,
  output strobes_t                     stb
);
  localparam int STAT_ADDR = NPADS;
  localparam int LVL_ADDR  = NPADS + 1;
  localparam padCfg_t CFG_RST = '{route: '0, debCode: '0, debEn: 1'b0,
                                  rxOff: 1'b0, invert: 1'b0, trig: TRIG_OFF};

  for (genvar p = 0; p < NPADS; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgVec[p] <= CFG_RST;
      else if (wrEn && addr == AW'(p))
        cfgVec[p] <= padCfg_t'(wrData[CFG_W-1:0]);
    end
  end

  always_comb begin
    stb.clrStb  = wrEn && (addr == AW'(STAT_ADDR));
    stb.clrMask = wrData;
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NPADS; p++)
      if (addr == AW'(p)) rdData = DATA_W'(cfgVec[p]);
    if (addr == AW'(STAT_ADDR)) rdData = DATA_W'(statusVec);
    if (addr == AW'(LVL_ADDR))  rdData = DATA_W'(levelVec);
  end
endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int NPADS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPADS-1:0]    padIn,
  input  logic                rtcTick,
  input  padCfg_t [NPADS-1:0] cfgVec,
  input  strobes_t            stb,
  output logic [NPADS-1:0]    statusVec,
  output logic [NPADS-1:0]    levelVec
);
  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    logic             syncA, syncB, filtQ, prevQ, statQ, sensed, evt, clrHit;
    logic [CNT_W-1:0] cnt, limit;
    logic [3:0]       code;

    // synchronizer
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= padIn[p];
        syncB <= syncA;
      end
    end

    assign sensed = syncB ^ cfgVec[p].invert;
    assign code   = (cfgVec[p].debCode < 4'(MIN_CODE)) ? 4'(MIN_CODE) : cfgVec[p].debCode;
    assign limit  = CNT_W'(1) << code;

    // debounce filter
    always_ff @(posedge clk) begin
      if (!rstN) begin
        filtQ <= 1'b0;
        cnt   <= '0;
      end else if (!cfgVec[p].debEn) begin
        filtQ <= sensed;
        cnt   <= '0;
      end else if (sensed == filtQ) begin
        cnt <= '0;
      end else if (rtcTick) begin
        if (cnt == limit - CNT_W'(1)) begin
          filtQ <= sensed;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end

    // event detection
    always_comb begin
      unique case (cfgVec[p].trig)
        TRIG_LEVEL: evt = filtQ;
        TRIG_EDGE:  evt = filtQ & ~prevQ;
        TRIG_BOTH:  evt = filtQ ^ prevQ;
        default:    evt = 1'b0;
      endcase
      evt = evt & ~cfgVec[p].rxOff;
    end

    assign clrHit = stb.clrStb & stb.clrMask[p];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ <= 1'b0;
        statQ <= 1'b0;
      end else begin
        prevQ <= filtQ;
        statQ <= (statQ & ~clrHit) | evt;
      end
    end

    assign statusVec[p] = statQ;
    assign levelVec[p]  = filtQ;
  end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPADS = 4,
  parameter int AW    = $clog2(NPADS + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPADS-1:0]    padIn,
  input  logic                rtcTick,
  input  logic                wrEn,
  input  logic [AW-1:0]       addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_DEST-1:0] dstIrq
);
  padCfg_t [NPADS-1:0] cfgVec;
  strobes_t            stb;
  logic [NPADS-1:0]    statusVec;
  logic [NPADS-1:0]    levelVec;

  gpio_evt_ctrl #(.NPADS(NPADS), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .statusVec(statusVec), .levelVec(levelVec),
    .cfgVec(cfgVec), .stb(stb)
  );

  gpio_evt_dp #(.NPADS(NPADS)) dp_i (
    .clk(clk), .rstN(rstN), .padIn(padIn), .rtcTick(rtcTick),
    .cfgVec(cfgVec), .stb(stb), .statusVec(statusVec), .levelVec(levelVec)
  );

  always_comb begin
    for (int d = 0; d < NUM_DEST; d++) begin
      dstIrq[d] = 1'b0;
      for (int p = 0; p < NPADS; p++)
        dstIrq[d] = dstIrq[d] | (statusVec[p] & cfgVec[p].route[d]);
    end
  end
endmodule

// File: rtl/gpio_event_detect_chk.sv
module gpio_event_detect_chk
  import gpio_evt_pkg::*;
#(
  parameter int NPADS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                rtcTick,
  input padCfg_t [NPADS-1:0] cfgVec,
  input strobes_t            stb,
  input logic [NPADS-1:0]    statusVec,
  input logic [NPADS-1:0]    levelVec,
  input logic [NUM_DEST-1:0] dstIrq
);
  for (genvar p = 0; p < NPADS; p++) begin : g_chk
    // R8
    rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgVec[p].rxOff && !statusVec[p]) |=> !statusVec[p]);
    // R5
    trig_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgVec[p].trig == TRIG_OFF && !statusVec[p]) |=> !statusVec[p]);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusVec[p] && !(stb.clrStb && stb.clrMask[p])) |=> statusVec[p]);
    // R9
    deb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgVec[p].debEn && !rtcTick) |=> $stable(levelVec[p]));
  end

  // R11
  route_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec == '0) |-> (dstIrq == '0));
endmodule

bind gpio_event_detect gpio_event_detect_chk #(.NPADS(NPADS)) chk_i (
  .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .cfgVec(cfgVec), .stb(stb),
  .statusVec(statusVec), .levelVec(levelVec), .dstIrq(dstIrq)
);

// File: tb/gpio_event_detect_tb_top.sv
module gpio_event_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPADS      = 4;
  localparam int AW         = $clog2(NPADS + 2);
  localparam int STAT       = NPADS;
  localparam int LVL        = NPADS + 1;
  localparam int TICK_DIV   = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NPADS-1:0] padIn = '0;
  logic             rtcTick = 1'b0;
  logic             wrEn = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [15:0]      wrData = '0;
  logic [15:0]      rdData;
  logic [3:0]       dstIrq;
  logic             tickOn = 1'b0;
  int               nChecks = 0;
  int               nFail = 0;

  gpio_event_detect #(.NPADS(NPADS)) dut_i (
    .clk(clk), .rstN(rstN), .padIn(padIn), .rtcTick(rtcTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .dstIrq(dstIrq)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      if (tickOn) begin
        tc++;
        rtcTick = (tc % TICK_DIV == 0);
      end else begin
        rtcTick = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(int a, logic [15:0] d);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(int a, output logic [15:0] d);
    addr = AW'(a);
    #1;
    d = rdData;
  endtask

  function automatic logic [15:0] cfgWord(int trig, bit inv, bit rxOff, bit deb,
                                          int code, logic [3:0] route);
    return {3'b0, route, 4'(code), deb, rxOff, inv, 2'(trig)};
  endfunction

  function automatic bit expEvt(int trig, bit inv, bit v0, bit v1);
    bit s0 = v0 ^ inv;
    bit s1 = v1 ^ inv;
    case (trig)
      0: return s0 | s1;
      1: return s1 & ~s0;
      3: return s1 ^ s0;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R12 reset state
    regRead(STAT, d); checkEq("R12 status", d, 0);
    regRead(LVL, d);  checkEq("R12 level", d, 0);
    regRead(0, d);    checkEq("R12 cfg", d, 16'h0002);
    checkEq("R12 dst", dstIrq, 0);

    // R1 synchronizer latency, R2 level mode
    regWrite(0, cfgWord(0, 0, 0, 0, 0, 4'b0000));
    padIn[0] = 1'b1;
    waitCyc(2);
    regRead(LVL, d); checkEq("R1 early", d[0], 0);
    waitCyc(1);
    regRead(LVL, d); checkEq("R1 visible", d[0], 1);
    waitCyc(2);
    regRead(STAT, d); checkEq("R2 level event", d[0], 1);
    // R7 clear while asserted re-sets
    regWrite(STAT, 16'h0001);
    regRead(STAT, d); checkEq("R7 level re-set", d[0], 1);
    padIn[0] = 1'b0; waitCyc(6);
    regWrite(STAT, 16'h0001);
    regRead(STAT, d); checkEq("R7 cleared", d[0], 0);
    // R6 invert
    regWrite(0, cfgWord(0, 1, 0, 0, 0, 4'b0000));
    waitCyc(6); regWrite(STAT, 16'h000F); waitCyc(1);
    regRead(LVL, d);  checkEq("R6 inverted level", d[0], 1);
    regRead(STAT, d); checkEq("R6 inverted event", d[0], 1);
    regWrite(0, cfgWord(2, 0, 0, 0, 0, 4'b0000));

    // R3 single edge
    regWrite(1, cfgWord(1, 0, 0, 0, 0, 4'b0000));
    waitCyc(6); regWrite(STAT, 16'h000F);
    padIn[1] = 1'b1; waitCyc(6);
    regRead(STAT, d); checkEq("R3 rising", d[1], 1);
    regWrite(STAT, 16'h0002);
    padIn[1] = 1'b0; waitCyc(6);
    regRead(STAT, d); checkEq("R3 fall ignored", d[1], 0);
    regWrite(1, cfgWord(1, 1, 0, 0, 0, 4'b0000));
    waitCyc(6); regWrite(STAT, 16'h000F);
    padIn[1] = 1'b1; waitCyc(6);
    regRead(STAT, d); checkEq("R3 inv rise ignored", d[1], 0);
    padIn[1] = 1'b0; waitCyc(6);
    regRead(STAT, d); checkEq("R3 inv falling", d[1], 1);

    // R4 both edges
    regWrite(1, cfgWord(3, 0, 0, 0, 0, 4'b0000));
    waitCyc(6); regWrite(STAT, 16'h000F);
    padIn[1] = 1'b1; waitCyc(6);
    regRead(STAT, d); checkEq("R4 rise", d[1], 1);
    regWrite(STAT, 16'h0002);
    padIn[1] = 1'b0; waitCyc(6);
    regRead(STAT, d); checkEq("R4 fall", d[1], 1);
    regWrite(1, cfgWord(2, 0, 0, 0, 0, 4'b0000));

    // R5 off, R6 level still readable
    regWrite(STAT, 16'h000F);
    padIn[2] = 1'b1; waitCyc(6);
    regRead(STAT, d); checkEq("R5 off no event", d[2], 0);
    regRead(LVL, d);  checkEq("R6 level while off", d[2], 1);
    padIn[2] = 1'b0; waitCyc(6);

    // R8 receive off
    regWrite(3, cfgWord(0, 0, 1, 0, 0, 4'b1111));
    padIn[3] = 1'b1; waitCyc(6);
    regRead(STAT, d); checkEq("R8 rx off status", d[3], 0);
    checkEq("R8 rx off dst", dstIrq, 0);
    padIn[3] = 1'b0;
    regWrite(3, cfgWord(2, 0, 0, 0, 0, 4'b0000));

    // R11 routing
    regWrite(0, cfgWord(0, 0, 0, 0, 0, 4'b0101));
    regWrite(1, cfgWord(1, 0, 0, 0, 0, 4'b1000));
    waitCyc(6); regWrite(STAT, 16'h000F);
    padIn[0] = 1'b1; waitCyc(6);
    checkEq("R11 dual route", dstIrq, 4'b0101);
    padIn[1] = 1'b1; waitCyc(6);
    checkEq("R11 merged routes", dstIrq, 4'b1101);
    padIn[0] = 1'b0; padIn[1] = 1'b0; waitCyc(6);
    regWrite(STAT, 16'h000F);
    checkEq("R11 cleared", dstIrq, 0);
    regWrite(0, cfgWord(2, 0, 0, 0, 0, 4'b0000));
    regWrite(1, cfgWord(2, 0, 0, 0, 0, 4'b0000));

    // R9 debounce code 3 (8 ticks)
    tickOn = 1'b1;
    regWrite(2, cfgWord(1, 0, 0, 1, 3, 4'b0000));
    waitCyc(4); regWrite(STAT, 16'h000F);
    padIn[2] = 1'b1; waitCyc(16);
    regRead(LVL, d); checkEq("R9 code3 early", d[2], 0);
    waitCyc(44);
    regRead(LVL, d); checkEq("R9 code3 done", d[2], 1);
    regRead(STAT, d); checkEq("R9 debounced edge", d[2], 1);
    // R10 bounce restarts count
    regWrite(STAT, 16'h000F);
    padIn[2] = 1'b0; waitCyc(24);
    padIn[2] = 1'b1; waitCyc(8);
    padIn[2] = 1'b0; waitCyc(24);
    regRead(LVL, d); checkEq("R10 bounce held", d[2], 1);
    waitCyc(40);
    regRead(LVL, d); checkEq("R10 settled", d[2], 0);
    // R9 code 4 (16 ticks)
    regWrite(2, cfgWord(1, 0, 0, 1, 4, 4'b0000));
    padIn[2] = 1'b1; waitCyc(48);
    regRead(LVL, d); checkEq("R9 code4 early", d[2], 0);
    waitCyc(40);
    regRead(LVL, d); checkEq("R9 code4 done", d[2], 1);
    // R9 code 0 acts as 3
    regWrite(2, cfgWord(1, 0, 0, 1, 0, 4'b0000));
    padIn[2] = 1'b0; waitCyc(16);
    regRead(LVL, d); checkEq("R9 code0 early", d[2], 1);
    waitCyc(44);
    regRead(LVL, d); checkEq("R9 code0 done", d[2], 0);
    tickOn = 1'b0;
    regWrite(2, cfgWord(2, 0, 0, 0, 0, 4'b0000));

    // Random trigger/invert patterns (R2 R3 R4 R5)
    for (int i = 0; i < 40; i++) begin
      int  p    = $urandom_range(0, NPADS - 1);
      int  trig = $urandom_range(0, 3);
      bit  inv  = 1'($urandom_range(0, 1));
      bit  v0   = 1'($urandom_range(0, 1));
      bit  v1   = 1'($urandom_range(0, 1));
      regWrite(p, cfgWord(trig, inv, 0, 0, 0, 4'b0000));
      padIn[p] = v0; waitCyc(6);
      regWrite(STAT, 16'h000F);
      padIn[p] = v1; waitCyc(6);
      regRead(STAT, d);
      checkEq($sformatf("R2/R3/R4/R5 random trig%0d inv%0d %0d->%0d", trig, inv, v0, v1),
              d[p], expEvt(trig, inv, v0, v1));
      regWrite(p, cfgWord(2, 0, 0, 0, 0, 4'b0000));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule